// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single bus transfers for a processor core over a bus on which the low address bits and the data share one set of lines. A core-side request carries a 20-bit address, write data, an upper-byte enable, a direction flag, a memory/I-O flag and four status bits. The sequencer steps through four clock states per transfer. In the first state it puts the address out with a latch strobe. In the following states the same lines carry data, and the upper address lines switch to status. The read, write and transceiver controls are timed around that switch.

A slow target stretches a transfer by holding the ready input low. Each low sample at the end of the third state adds one wait state. Another bus master can ask for the bus with a hold request. The request is granted only between transfers. During the grant every bus output is released, and the pins are modelled as output values with separate enables. A build option lets a request that is waiting during the last state start the next transfer with no idle cycle in between.

Top module: `busctl_top`

## Requirements
- R1: While reset is high and in the first idle cycle after it, ale is 0; rd_n, wr_n and den_n are 1; hlda, done and ad_oe are 0; ctl_oe is 1.
- R2: A request is taken (req_ack high) when the block is idle, req_valid is 1 and hold is 0. The next cycle is T1, and T1 lasts one cycle. In T1: ale=1, ad_out holds address bits 15:0 with ad_oe=1, ahs_out holds address bits 19:16, bhs_n = NOT req_hi_en, m_io = req_mem and dt_r = req_write.
- R3: From T2 through T4, ahs_out carries the four status bits latched with the request, and bhs_n carries the S7_LEVEL parameter (default 0).
- R4: On a read, rd_n and den_n are 0 in T2, T3 and every wait state, and 1 in T4. dt_r is 0 from T1 to T4. ad_oe is 0 from T2 on.
- R5: On a write, wr_n is 0 in T2, T3 and every wait state, and 1 in T4. den_n is 0 from T2 through T4. dt_r is 1. ad_oe stays 1 and ad_out holds the write data from T2 through T4.
- R6: ready is sampled only at the edge that ends T3 or a wait state. Each 0 sample adds one wait state, so a transfer with n low samples spans 4+n cycles from T1 to T4 inclusive. ready has no effect in T1 or T2.
- R7: done is 1 exactly in T4. On a read, rd_data in T4 equals ad_in as sampled at the edge that ended the last T3/wait state.
- R8: A hold request is granted (hlda=1) only in the cycle after an idle or T4 cycle in which hold was 1, never during T1 to T3 or a wait state. While hlda is 1, ctl_oe and ad_oe are 0 and no strobe is active.
- R9: One cycle after hold returns to 0, hlda returns to 0 and the block is idle again.
- R10: While hold is 1, req_ack stays 0 and no T1 starts.
- R11: With BACK_TO_BACK=1 (default), a request presented during T4 with hold low is taken in T4, and the next cycle is its T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request present |
| req_ack | output | 1 | Request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_hi_en | input | 1 | Enable upper data byte |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_stat | input | ADDR_W-DATA_W | Status bits shown on upper lines after T1 |
| done | output | 1 | Transfer in its last state |
| rd_data | output | DATA_W | Captured read data |
| ad_out | output | DATA_W | Shared address/data lines, driven value |
| ad_in | input | DATA_W | Shared address/data lines, received value |
| ad_oe | output | 1 | Drive enable for shared lines |
| ahs_out | output | ADDR_W-DATA_W | Upper address / status lines |
| bhs_n | output | 1 | Upper-byte enable (T1) / S7 status |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = out |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| ctl_oe | output | 1 | Drive enable for address/status/control pins |
| ready | input | 1 | Target ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant |

## Verification
All pin values are decoded without registers from the state register. Each state's outputs therefore become valid just after the edge that enters that state: T1 comes one edge after the accepting cycle, T4 comes 3+n edges after T1, and a grant or release shows one edge after the deciding cycle. The bench changes inputs on the falling edge. It samples 2 ns after each rising edge and checks every state of the transfer in sequence, so the T4 check on done also fixes the wait-state count. It sweeps direction, space, byte enable and zero to three wait states, then covers hold in idle, hold raised mid-transfer, and a request chained from T4.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
   typedef enum logic [2:0] {
      BS_IDLE = 3'd0,
      BS_T1   = 3'd1,
      BS_T2   = 3'd2,
      BS_T3   = 3'd3,
      BS_TW   = 3'd4,
      BS_T4   = 3'd5,
      BS_HOLD = 3'd6
   } bus_st_e;
endpackage

// File: rtl/busctl_seq.sv
module busctl_seq
   import busctl_pkg::*;
#(
   parameter bit BACK_TO_BACK = 1'b1
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    req_valid,
   input  logic    ready,
   input  logic    hold,
   output bus_st_e st,
   output logic    take,
   output logic    cap
);
   logic    chain_ok;
   bus_st_e st_d;

   generate
      if (BACK_TO_BACK) begin : g_chain
         assign chain_ok = 1'b1;
      end else begin : g_nochain
         assign chain_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      take = req_valid && !hold &&
             ((st == BS_IDLE) || ((st == BS_T4) && chain_ok));
      cap  = ((st == BS_T3) || (st == BS_TW)) && ready;
   end

   always_comb begin
      st_d = st;
      case (st)
         BS_IDLE: st_d = hold ? BS_HOLD : (take ? BS_T1 : BS_IDLE);
         BS_T1:   st_d = BS_T2;
         BS_T2:   st_d = BS_T3;
         BS_T3,
         BS_TW:   st_d = ready ? BS_T4 : BS_TW;
         BS_T4:   st_d = hold ? BS_HOLD : (take ? BS_T1 : BS_IDLE);
         BS_HOLD: st_d = hold ? BS_HOLD : BS_IDLE;
         default: st_d = BS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= BS_IDLE;
      else     st <= st_d;
   end
endmodule

// File: rtl/busctl_pins.sv
module busctl_pins
   import busctl_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 16,
   parameter bit S7_LEVEL = 1'b0,
   localparam int HI_W    = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  bus_st_e           st,
   input  logic              take,
   input  logic              cap,
   input  logic              req_write,
   input  logic              req_mem,
   input  logic              req_hi_en,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [HI_W-1:0]   req_stat,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [HI_W-1:0]   ahs_out,
   output logic              bhs_n,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              dt_r,
   output logic              m_io,
   output logic              ctl_oe
);
   logic              wr_q, mem_q, hi_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [HI_W-1:0]   stat_q;
   logic              in_t1, in_strb, in_data, in_cyc;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q    <= 1'b0;
         mem_q   <= 1'b0;
         hi_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         stat_q  <= '0;
      end else if (take) begin
         wr_q    <= req_write;
         mem_q   <= req_mem;
         hi_q    <= req_hi_en;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         stat_q  <= req_stat;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)      rd_data <= '0;
      else if (cap) rd_data <= ad_in;
   end

   always_comb begin
      in_t1   = (st == BS_T1);
      in_strb = (st == BS_T2) || (st == BS_T3) || (st == BS_TW);
      in_data = in_strb || (st == BS_T4);
      in_cyc  = in_t1 || in_data;
   end

   always_comb begin
      ale     = in_t1;
      ctl_oe  = (st != BS_HOLD);
      m_io    = mem_q;
      dt_r    = in_cyc ? wr_q : 1'b1;
      rd_n    = !(in_strb && !wr_q);
      wr_n    = !(in_strb && wr_q);
      den_n   = !(in_data && (wr_q || (st != BS_T4)));
      ad_oe   = in_t1 || (in_data && wr_q);
      ad_out  = '0;
      ahs_out = '0;
      bhs_n   = 1'b1;
      if (in_t1) begin
         ad_out  = addr_q[DATA_W-1:0];
         ahs_out = addr_q[ADDR_W-1:DATA_W];
         bhs_n   = !hi_q;
      end else if (in_data) begin
         ad_out  = wr_q ? wdata_q : '0;
         ahs_out = stat_q;
         bhs_n   = S7_LEVEL;
      end
   end
endmodule

// File: rtl/busctl_top.sv
module busctl_top
   import busctl_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 16,
   parameter bit S7_LEVEL     = 1'b0,
   parameter bit BACK_TO_BACK = 1'b1,
   localparam int HI_W        = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ack,
   input  logic              req_write,
   input  logic              req_mem,
   input  logic              req_hi_en,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [HI_W-1:0]   req_stat,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ad_out,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ad_oe,
   output logic [HI_W-1:0]   ahs_out,
   output logic              bhs_n,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              dt_r,
   output logic              m_io,
   output logic              ctl_oe,
   input  logic              ready,
   input  logic              hold,
   output logic              hlda
);
   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data
         $error("busctl_top: DATA_W must be even and at least 2");
      end
      if (HI_W < 1) begin : g_bad_addr
         $error("busctl_top: ADDR_W must exceed DATA_W");
      end
   endgenerate

   bus_st_e st_q;
   logic    take, cap;

   busctl_seq #(.BACK_TO_BACK(BACK_TO_BACK)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .ready     (ready),
      .hold      (hold),
      .st        (st_q),
      .take      (take),
      .cap       (cap)
   );

   busctl_pins #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .S7_LEVEL (S7_LEVEL)
   ) u_pins (
      .clk       (clk),
      .rst       (rst),
      .st        (st_q),
      .take      (take),
      .cap       (cap),
      .req_write (req_write),
      .req_mem   (req_mem),
      .req_hi_en (req_hi_en),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_stat  (req_stat),
      .ad_in     (ad_in),
      .rd_data   (rd_data),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .ahs_out   (ahs_out),
      .bhs_n     (bhs_n),
      .ale       (ale),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .den_n     (den_n),
      .dt_r      (dt_r),
      .m_io      (m_io),
      .ctl_oe    (ctl_oe)
   );

   assign req_ack = take;
   assign done    = (st_q == BS_T4);
   assign hlda    = (st_q == BS_HOLD);
endmodule

// File: rtl/busctl_chk.sv
module busctl_chk
   import busctl_pkg::*;
(
   input logic    clk,
   input logic    rst,
   input bus_st_e st,
   input logic    ready,
   input logic    hold,
   input logic    hlda,
   input logic    ale,
   input logic    rd_n,
   input logic    wr_n,
   input logic    den_n,
   input logic    dt_r,
   input logic    ad_oe,
   input logic    ctl_oe
);
   // R2
   ale_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ale |=> !ale);

   // R4
   read_dir_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> (!dt_r && !ad_oe && !den_n));

   // R5
   write_drive_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> (dt_r && ad_oe && !den_n));

   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      rd_n || wr_n);

   // R6
   wait_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (((st == BS_T3) || (st == BS_TW)) && !ready) |=> (st == BS_TW));

   // R8
   hold_float_chk: assert property (@(posedge clk) disable iff (rst)
      hlda |-> (!ctl_oe && !ad_oe && rd_n && wr_n && den_n && !ale));

   // R8
   grant_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hlda) |-> ($past(hold) &&
                       (($past(st) == BS_IDLE) || ($past(st) == BS_T4))));

   // R9
   release_chk: assert property (@(posedge clk) disable iff (rst)
      (hlda && !hold) |=> !hlda);
endmodule

bind busctl_top busctl_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .st     (st_q),
   .ready  (ready),
   .hold   (hold),
   .hlda   (hlda),
   .ale    (ale),
   .rd_n   (rd_n),
   .wr_n   (wr_n),
   .den_n  (den_n),
   .dt_r   (dt_r),
   .ad_oe  (ad_oe),
   .ctl_oe (ctl_oe)
);

// File: tb/sim_busctl_top.sv
module sim_busctl_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_hi_en = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [3:0]  req_stat = '0;
   logic [15:0] ad_in = '0;
   logic        ready = 1'b1, hold = 1'b0;
   logic        req_ack, done, ad_oe, bhs_n, ale, rd_n, wr_n, den_n, dt_r, m_io, ctl_oe, hlda;
   logic [15:0] rd_data, ad_out;
   logic [3:0]  ahs_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   busctl_top u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ack(req_ack),
      .req_write(req_write), .req_mem(req_mem), .req_hi_en(req_hi_en),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_stat(req_stat),
      .done(done), .rd_data(rd_data), .ad_out(ad_out), .ad_in(ad_in),
      .ad_oe(ad_oe), .ahs_out(ahs_out), .bhs_n(bhs_n), .ale(ale),
      .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .m_io(m_io),
      .ctl_oe(ctl_oe), .ready(ready), .hold(hold), .hlda(hlda)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // strobes expected during T2, T3 and wait states
   task automatic chk_mid(input string ph, input bit wr, input logic [15:0] d, input logic [3:0] s);
      chk({ph, " R3 status"}, {28'd0, ahs_out}, {28'd0, s});
      chk({ph, " R3 s7"}, {31'd0, bhs_n}, 32'd0);
      chk({ph, " R2 ale low"}, {31'd0, ale}, 32'd0);
      chk({ph, " R4 rd_n"}, {31'd0, rd_n}, {31'd0, wr});
      chk({ph, " R5 wr_n"}, {31'd0, wr_n}, {31'd0, !wr});
      chk({ph, " R4 R5 den_n"}, {31'd0, den_n}, 32'd0);
      chk({ph, " R4 R5 dt_r"}, {31'd0, dt_r}, {31'd0, wr});
      chk({ph, " R4 R5 ad_oe"}, {31'd0, ad_oe}, {31'd0, wr});
      if (wr) chk({ph, " R5 wdata"}, {16'd0, ad_out}, {16'd0, d});
      chk({ph, " R7 done low"}, {31'd0, done}, 32'd0);
   endtask

   task automatic run_cyc(input bit wr, input bit mio, input bit hi,
                          input logic [19:0] a, input logic [15:0] d,
                          input logic [3:0] s, input int nw,
                          input bit hold_mid, input bit b2b);
      logic [15:0] rv;
      logic [19:0] a2;
      rv = d ^ 16'h5A5A;
      a2 = a ^ 20'hF0F0F;
      @(negedge clk);
      req_write = wr; req_mem = mio; req_hi_en = hi;
      req_addr = a; req_wdata = d; req_stat = s; req_valid = 1'b1;
      #1 chk("R2 ack idle", {31'd0, req_ack}, 32'd1);
      tick();
      chk("R2 T1 ale", {31'd0, ale}, 32'd1);
      chk("R2 T1 low addr", {16'd0, ad_out}, {16'd0, a[15:0]});
      chk("R2 T1 ad_oe", {31'd0, ad_oe}, 32'd1);
      chk("R2 T1 high addr", {28'd0, ahs_out}, {28'd0, a[19:16]});
      chk("R2 T1 bhs_n", {31'd0, bhs_n}, {31'd0, !hi});
      chk("R2 T1 m_io", {31'd0, m_io}, {31'd0, mio});
      chk("R2 T1 dt_r", {31'd0, dt_r}, {31'd0, wr});
      chk("R2 T1 strobes idle", {29'd0, rd_n, wr_n, den_n}, 32'd7);
      @(negedge clk);
      req_valid = 1'b0; ready = 1'b0;   // R6: ready low in T2 must not stall
      req_addr = ~a; req_wdata = ~d; req_stat = ~s; req_write = !wr;
      tick();
      chk_mid("T2", wr, d, s);
      chk("T2 R2 m_io held", {31'd0, m_io}, {31'd0, mio});
      @(negedge clk);
      if (hold_mid) hold = 1'b1;
      tick();
      chk_mid("T3", wr, d, s);
      chk("T3 R8 no grant mid", {31'd0, hlda}, 32'd0);
      for (int k = 0; k <= nw; k++) begin
         @(negedge clk);
         ready = (k < nw) ? 1'b0 : 1'b1;
         ad_in = (k < nw) ? ~rv : rv;
         if (k == nw && b2b) begin
            req_write = 1'b1; req_mem = 1'b1; req_hi_en = 1'b1;
            req_addr = a2; req_wdata = d; req_stat = s; req_valid = 1'b1;
         end
         tick();
         if (k < nw) begin
            chk_mid("TW R6", wr, d, s);
            if (hold_mid) chk("TW R8 no grant", {31'd0, hlda}, 32'd0);
         end else begin
            chk("T4 R6 R7 done", {31'd0, done}, 32'd1);
            chk("T4 R4 R5 rd_n wr_n", {30'd0, rd_n, wr_n}, 32'd3);
            chk("T4 R4 R5 den_n", {31'd0, den_n}, {31'd0, !wr});
            chk("T4 R3 status", {28'd0, ahs_out}, {28'd0, s});
            if (wr) chk("T4 R5 ad_oe", {31'd0, ad_oe}, 32'd1);
            else    chk("T4 R7 rd_data", {16'd0, rd_data}, {16'd0, rv});
            if (hold_mid) chk("T4 R8 no grant", {31'd0, hlda}, 32'd0);
         end
      end
      if (b2b) begin
         chk("R11 ack in T4", {31'd0, req_ack}, 32'd1);
         tick();
         chk("R11 chained T1 ale", {31'd0, ale}, 32'd1);
         chk("R11 chained addr", {16'd0, ad_out}, {16'd0, a2[15:0]});
         @(negedge clk);
         req_valid = 1'b0; ready = 1'b1;
         repeat (4) @(posedge clk);
         #2 chk("R11 chained done", {31'd0, done}, 32'd0);
      end else if (hold_mid) begin
         tick();
         chk("R8 grant after T4", {31'd0, hlda}, 32'd1);
         chk("R8 released pins", {30'd0, ctl_oe, ad_oe}, 32'd0);
         @(negedge clk);
         hold = 1'b0;
         tick();
         chk("R9 hlda drop", {31'd0, hlda}, 32'd0);
         chk("R9 ctl_oe back", {31'd0, ctl_oe}, 32'd1);
      end else begin
         tick();
         chk("R1 idle after", {30'd0, ale, done}, 32'd0);
         chk("R1 idle den_n", {31'd0, den_n}, 32'd1);
      end
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset strobes", {28'd0, ale, rd_n, wr_n, den_n}, 32'h7);
      chk("R1 reset hlda done oe", {29'd0, hlda, done, ad_oe}, 32'd0);
      chk("R1 reset ctl_oe", {31'd0, ctl_oe}, 32'd1);
      @(negedge clk);
      rst = 1'b0;
      tick();
      chk("R1 first idle", {29'd0, ale, hlda, done}, 32'd0);

      // sweep: direction, space, byte enable, 0..3 wait states
      for (int i = 0; i < 32; i++) begin
         run_cyc(i[0], i[1], i[2], 20'(32'h1B3C5 * (i + 1)),
                 16'(32'h9E37 * (i + 3)), i[3:0] ^ 4'h6, i / 8, 1'b0, 1'b0);
      end

      // R10: hold while idle blocks requests
      @(negedge clk);
      hold = 1'b1; req_valid = 1'b1; req_write = 1'b0;
      #1 chk("R10 no ack under hold", {31'd0, req_ack}, 32'd0);
      tick();
      chk("R8 idle grant", {31'd0, hlda}, 32'd1);
      chk("R8 idle release oe", {30'd0, ctl_oe, ad_oe}, 32'd0);
      repeat (3) begin
         tick();
         chk("R10 no T1 under hold", {30'd0, ale, req_ack}, 32'd0);
      end
      @(negedge clk);
      hold = 1'b0; req_valid = 1'b0;
      tick();
      chk("R9 idle release", {31'd0, hlda}, 32'd0);

      // R8: hold raised mid-transfer waits for T4
      run_cyc(1'b0, 1'b1, 1'b1, 20'hABCDE, 16'h1234, 4'h9, 2, 1'b1, 1'b0);
      run_cyc(1'b1, 1'b0, 1'b0, 20'h0F00F, 16'hBEEF, 4'h3, 0, 1'b1, 1'b0);

      // R11: request chained from T4
      run_cyc(1'b0, 1'b1, 1'b0, 20'h54321, 16'h7777, 4'hC, 1, 1'b0, 1'b1);
      run_cyc(1'b1, 1'b1, 1'b1, 20'h13579, 16'h2468, 4'h5, 0, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule